// File: doc/BRIEF.md
# Serial flash probe and unprotect sequencer

This block runs one fixed command sequence over an SPI link to a serial NOR flash, starting as soon as reset is released. It first reads the flash's three identification bytes, checks the vendor and family bytes, and turns the size byte into an erase-sector size (as a power-of-two shift) and a sector count. The rest of the chip uses these values to address the device.

If the part is recognised, the block then clears the status register's write-protect bits so that later program and erase traffic can proceed. This is a two-frame exchange. First a status-write-enable opcode is sent alone. Then a status-write opcode is sent with a zero data byte. When the sequence ends, the block raises `done_o` and holds it. If the part is not recognised, the unprotect frames are skipped and `error_o` is raised with `done_o`.

The link runs in mode 0 (clock idles low, data sampled on the rising edge), eight bits per byte, most significant bit first. The serial clock half-period is a parameter counted in system clocks.

Top module: `flash_probe_seq`

## Requirements
- R1: While `rst_ni` is low, `spi_cs_no` is 1, `spi_sclk_o` is 0, `done_o` and `error_o` are 0, and both geometry outputs are 0.
- R2: Mode 0 framing. `spi_sclk_o` is low whenever chip select is high. `spi_mosi_o` changes only while `spi_sclk_o` is low. Bytes go out MSB first. `spi_miso_i` is sampled on rising edges.
- R3: The first frame is four bytes: 0x9F, then three filler bytes of 0xA5. The bytes received during filler positions 1, 2 and 3 are taken as vendor, family and size, in that order.
- R4: The part is accepted only when the vendor byte is 0xBF and the family byte is 0x25. Otherwise, after the first frame, `done_o` and `error_o` both rise, no further frame is opened, and the geometry outputs stay 0.
- R5: A size byte of 0x4A gives a sector count of 1024. A size byte of 0x41 gives 512. Both give a sector shift of 12. Any other size byte is treated like a rejected part (R4).
- R6: For an accepted part, the second frame carries exactly one byte, 0x50.
- R7: The third frame carries exactly two bytes, 0x01 then 0x00. `done_o` rises with `error_o` low after this frame, and no fourth frame follows.
- R8: Between frames, and before the first frame, chip select stays high for at least `CS_GAP` (at least 2) system clocks.
- R9: Every high phase of `spi_sclk_o` lasts exactly `CLK_DIV` system clocks. Every low phase inside a frame lasts at least `CLK_DIV` system clocks.
- R10: Once `done_o` is set, it stays set until reset. While `done_o` is set, `error_o`, both geometry outputs and `spi_cs_no` (high) are all constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_cs_no | output | 1 | Flash chip select, active low |
| spi_sclk_o | output | 1 | Serial clock, idles low |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |
| done_o | output | 1 | Sequence finished (sticky) |
| error_o | output | 1 | Identification rejected (valid with done) |
| sector_shift_o | output | SHIFT_W | log2 of the erase-sector size in bytes |
| sector_count_o | output | COUNT_W | Number of erase sectors |

## Verification
A bad byte or frame counter shows up at once as a wrong opcode or a wrong frame length at the flash pins. It appears within one byte time, before `done_o` rises. A shifter that samples on the wrong edge, or fills the wrong way, misaligns the captured ID bytes. With the fixed accept values, that makes a valid part read as rejected by the end of the first frame. A divider fault changes the width of the very first high SCLK phase. A bad decode of the size byte appears on the geometry outputs as soon as `done_o` rises. Sweeping each of the three ID bytes across all 256 values exposes any accept or decode term that is too wide or too narrow.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;
  localparam logic [7:0] OP_READ_ID  = 8'h9F;
  localparam logic [7:0] FILLER      = 8'hA5;
  localparam logic [7:0] OP_SR_WEN   = 8'h50;
  localparam logic [7:0] OP_SR_WRITE = 8'h01;
  localparam logic [7:0] SR_CLEAR    = 8'h00;
  localparam logic [7:0] VENDOR_OK   = 8'hBF;
  localparam logic [7:0] FAMILY_OK   = 8'h25;
  localparam logic [7:0] SIZE_LARGE  = 8'h4A;
  localparam logic [7:0] SIZE_SMALL  = 8'h41;
  localparam int         SECT_SHIFT  = 12;
  localparam int         SECTS_LARGE = 1024;
  localparam int         SECTS_SMALL = 512;

  typedef enum logic [1:0] {ST_GAP, ST_LOAD, ST_WAIT, ST_DONE} seq_state_e;

  typedef struct packed {
    logic [7:0] vendor;
    logic [7:0] family;
    logic [7:0] size;
  } id_bytes_t;
endpackage

// File: rtl/spi_clk_gen.sv
module spi_clk_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       tick_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  logic [7:0] tx_sr;
  logic [2:0] bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      rx_o   <= '0;
      sclk_o <= 1'b0;
      mosi_o <= 1'b0;
      tx_sr  <= '0;
      bit_q  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        tx_sr  <= tx_i;
        mosi_o <= tx_i[7];
        sclk_o <= 1'b0;
        bit_q  <= '0;
      end else if (busy_o && tick_i) begin
        if (!sclk_o) begin
          sclk_o <= 1'b1;                    // rising: sample
          rx_o   <= {rx_o[6:0], miso_i};
        end else begin
          sclk_o <= 1'b0;                    // falling: shift
          if (bit_q == 3'd7) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bit_q  <= bit_q + 1'b1;
            tx_sr  <= {tx_sr[6:0], 1'b0};
            mosi_o <= tx_sr[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/flash_id_decode.sv
module flash_id_decode
  import flash_probe_pkg::*;
#(
  parameter int SHIFT_W = 5,
  parameter int COUNT_W = 11
) (
  input  id_bytes_t          id_i,
  output logic               ok_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic [COUNT_W-1:0] count_o
);
  logic family_ok;
  assign family_ok = (id_i.vendor == VENDOR_OK) && (id_i.family == FAMILY_OK);

  always_comb begin
    ok_o    = 1'b0;
    shift_o = '0;
    count_o = '0;
    if (family_ok) begin
      unique case (id_i.size)
        SIZE_LARGE: begin
          ok_o = 1'b1; shift_o = SHIFT_W'(SECT_SHIFT); count_o = COUNT_W'(SECTS_LARGE);
        end
        SIZE_SMALL: begin
          ok_o = 1'b1; shift_o = SHIFT_W'(SECT_SHIFT); count_o = COUNT_W'(SECTS_SMALL);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flash_probe_seq.sv
module flash_probe_seq
  import flash_probe_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 2,
  parameter int SHIFT_W = 5,
  parameter int COUNT_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic               spi_cs_no,
  output logic               spi_sclk_o,
  output logic               spi_mosi_o,
  input  logic               spi_miso_i,
  output logic               done_o,
  output logic               error_o,
  output logic [SHIFT_W-1:0] sector_shift_o,
  output logic [COUNT_W-1:0] sector_count_o
);
  localparam int GAP_W = (CS_GAP > 2) ? $clog2(CS_GAP) : 1;

  seq_state_e         state_q;
  logic [1:0]         frame_q;
  logic [1:0]         idx_q;
  logic [GAP_W-1:0]   gap_q;
  id_bytes_t          id_q;
  logic [7:0]         tx_byte;
  logic               last_byte;
  logic               tick, busy, byte_done;
  logic [7:0]         rx_byte;
  logic               id_ok;
  logic [SHIFT_W-1:0] dec_shift;
  logic [COUNT_W-1:0] dec_count;

  always_comb begin
    unique case (frame_q)
      2'd0:    begin tx_byte = (idx_q == 2'd0) ? OP_READ_ID  : FILLER;   last_byte = (idx_q == 2'd3); end
      2'd1:    begin tx_byte = OP_SR_WEN;                                last_byte = 1'b1;            end
      default: begin tx_byte = (idx_q == 2'd0) ? OP_SR_WRITE : SR_CLEAR; last_byte = (idx_q == 2'd1); end
    endcase
  end

  spi_clk_gen #(.DIV(CLK_DIV)) u_clk (
    .clk_i, .rst_ni, .en_i(busy), .tick_o(tick)
  );

  spi_byte_shift u_shift (
    .clk_i, .rst_ni,
    .start_i(state_q == ST_LOAD),
    .tx_i   (tx_byte),
    .tick_i (tick),
    .miso_i (spi_miso_i),
    .busy_o (busy),
    .done_o (byte_done),
    .rx_o   (rx_byte),
    .sclk_o (spi_sclk_o),
    .mosi_o (spi_mosi_o)
  );

  flash_id_decode #(.SHIFT_W(SHIFT_W), .COUNT_W(COUNT_W)) u_dec (
    .id_i(id_q), .ok_o(id_ok), .shift_o(dec_shift), .count_o(dec_count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_GAP;
      frame_q        <= '0;
      idx_q          <= '0;
      gap_q          <= '0;
      id_q           <= '0;
      spi_cs_no      <= 1'b1;
      done_o         <= 1'b0;
      error_o        <= 1'b0;
      sector_shift_o <= '0;
      sector_count_o <= '0;
    end else begin
      unique case (state_q)
        ST_GAP: begin
          if (gap_q == GAP_W'(CS_GAP - 1)) begin
            gap_q <= '0;
            if (frame_q == 2'd3) begin
              done_o  <= 1'b1;
              state_q <= ST_DONE;
            end else if (frame_q == 2'd1 && !id_ok) begin
              done_o  <= 1'b1;
              error_o <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              if (frame_q == 2'd1) begin
                sector_shift_o <= dec_shift;
                sector_count_o <= dec_count;
              end
              spi_cs_no <= 1'b0;
              state_q   <= ST_LOAD;
            end
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_LOAD: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (byte_done) begin
            if (frame_q == 2'd0) begin
              unique case (idx_q)
                2'd1:    id_q.vendor <= rx_byte;
                2'd2:    id_q.family <= rx_byte;
                2'd3:    id_q.size   <= rx_byte;
                default: ;
              endcase
            end
            if (last_byte) begin
              spi_cs_no <= 1'b1;
              frame_q   <= frame_q + 1'b1;
              idx_q     <= '0;
              state_q   <= ST_GAP;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_LOAD;
            end
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/flash_probe_seq_chk.sv
module flash_probe_seq_chk #(
  parameter int CLK_DIV = 4,
  parameter int SHIFT_W = 5,
  parameter int COUNT_W = 11
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               spi_cs_no,
  input logic               spi_sclk_o,
  input logic               spi_mosi_o,
  input logic               done_o,
  input logic               error_o,
  input logic [SHIFT_W-1:0] sector_shift_o,
  input logic [COUNT_W-1:0] sector_count_o
);
  int hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hi_cnt <= 0;
    else if (spi_sclk_o) hi_cnt <= hi_cnt + 1;
    else                 hi_cnt <= 0;
  end

  a_r2_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);

  a_r2_mosi_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(spi_mosi_o) |-> !spi_sclk_o);

  a_r8_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |=> spi_cs_no);

  a_r9_sclk_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_sclk_o) |-> hi_cnt == CLK_DIV);

  a_r4_err_geo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (sector_count_o == '0 && sector_shift_o == '0));

  a_r10_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r10_err_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  a_r10_cs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> spi_cs_no);

  a_r10_geo_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ($stable(sector_count_o) && $stable(sector_shift_o) && $stable(error_o)));
endmodule

bind flash_probe_seq flash_probe_seq_chk #(
  .CLK_DIV(CLK_DIV), .SHIFT_W(SHIFT_W), .COUNT_W(COUNT_W)
) u_chk (
  .clk_i, .rst_ni, .spi_cs_no, .spi_sclk_o, .spi_mosi_o,
  .done_o, .error_o, .sector_shift_o, .sector_count_o
);

// File: tb/flash_probe_seq_tb.sv
module flash_probe_seq_tb;
  localparam int CLK_DIV = 2;
  localparam int CS_GAP  = 3;
  localparam int SHIFT_W = 5;
  localparam int COUNT_W = 11;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic spi_cs_no, spi_sclk_o, spi_mosi_o;
  logic spi_miso_i = 1'b0;
  logic done_o, error_o;
  logic [SHIFT_W-1:0] sector_shift_o;
  logic [COUNT_W-1:0] sector_count_o;

  always #2 clk_i = ~clk_i;

  flash_probe_seq #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .SHIFT_W(SHIFT_W), .COUNT_W(COUNT_W)) u_dut (
    .clk_i, .rst_ni, .spi_cs_no, .spi_sclk_o, .spi_mosi_o, .spi_miso_i,
    .done_o, .error_o, .sector_shift_o, .sector_count_o
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural flash responder
  logic [7:0] id_v, id_f, id_s;
  logic [7:0] got [0:15];
  int got_n, frames, byte_n, bit_n;
  int flen [0:3];
  logic [7:0] shin, cur_resp;
  bit armed = 1'b0;

  function automatic logic [7:0] resp(input int k);
    case (k)
      1: return id_v;
      2: return id_f;
      3: return id_s;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge spi_cs_no) if (armed) begin
    bit_n = 0; byte_n = 0; cur_resp = resp(0); spi_miso_i = cur_resp[7];
  end

  always @(posedge spi_cs_no) if (armed) begin
    if (frames < 4) flen[frames] = byte_n;
    frames++;
  end

  always @(posedge spi_sclk_o) if (armed && !spi_cs_no) begin
    shin = {shin[6:0], spi_mosi_o};
    bit_n++;
    if (bit_n == 8) begin
      if (got_n < 16) got[got_n] = shin;
      got_n++; byte_n++; bit_n = 0;
      cur_resp = resp(byte_n);
    end
  end

  always @(negedge spi_sclk_o) if (armed && !spi_cs_no)
    spi_miso_i = cur_resp[3'(7 - bit_n)];

  // port timing monitor
  int hi_run, lo_run, cs_hi_run, bad_hi, bad_lo, bad_mosi, bad_gap, bad_idle;
  logic prev_mosi, prev_cs;
  always @(negedge clk_i) if (armed && rst_ni) begin
    if (spi_sclk_o) begin
      if (lo_run > 0 && lo_run < CLK_DIV) bad_lo++;
      lo_run = 0; hi_run++;
    end else begin
      if (hi_run > 0 && hi_run != CLK_DIV) bad_hi++;
      hi_run = 0;
      if (!spi_cs_no) lo_run++; else lo_run = 0;
    end
    if (spi_mosi_o !== prev_mosi && spi_sclk_o) bad_mosi++;
    if (spi_cs_no && spi_sclk_o) bad_idle++;
    if (!spi_cs_no && prev_cs && cs_hi_run < CS_GAP) bad_gap++;
    cs_hi_run = spi_cs_no ? cs_hi_run + 1 : 0;
    prev_mosi = spi_mosi_o; prev_cs = spi_cs_no;
  end

  bit wd_hit = 1'b0;
  initial begin
    repeat (195000) @(posedge clk_i);
    wd_hit = 1'b1;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic run(input logic [7:0] v, input logic [7:0] f, input logic [7:0] s, input bit full);
    bit ok;
    int exp_cnt, exp_frames, wait_n;
    logic [7:0] exp_b [0:6];
    exp_b = '{8'h9F, 8'hA5, 8'hA5, 8'hA5, 8'h50, 8'h01, 8'h00};
    @(negedge clk_i);
    rst_ni = 1'b0;
    id_v = v; id_f = f; id_s = s;
    got_n = 0; frames = 0; byte_n = 0; bit_n = 0; spi_miso_i = 1'b0;
    hi_run = 0; lo_run = 0; cs_hi_run = 0; bad_hi = 0; bad_lo = 0;
    bad_mosi = 0; bad_gap = 0; bad_idle = 0; prev_cs = 1'b1; prev_mosi = 1'b0;
    for (int i = 0; i < 4; i++) flen[i] = 0;
    armed = 1'b1;
    repeat (2) @(negedge clk_i);
    if (full) begin
      // R1 reset state
      check(spi_cs_no === 1'b1, "R1 cs", spi_cs_no, 1);
      check(spi_sclk_o === 1'b0, "R1 sclk", spi_sclk_o, 0);
      check(done_o === 1'b0 && error_o === 1'b0, "R1 flags", {done_o, error_o}, 0);
      check(sector_shift_o === '0 && sector_count_o === '0, "R1 geometry", sector_count_o, 0);
    end
    rst_ni = 1'b1;
    wait_n = 0;
    while (done_o !== 1'b1 && wait_n < 3000) begin
      @(negedge clk_i); wait_n++;
    end
    ok = (v == 8'hBF) && (f == 8'h25) && (s == 8'h4A || s == 8'h41);
    exp_cnt = !ok ? 0 : (s == 8'h4A) ? 1024 : 512;
    exp_frames = ok ? 3 : 1;
    check(done_o === 1'b1, "R10 done reached", done_o, 1);
    check(error_o === !ok, ok ? "R7 no error" : "R4 error", error_o, !ok);
    check(sector_count_o == COUNT_W'(exp_cnt), "R5 sector count", sector_count_o, exp_cnt);
    check(sector_shift_o == SHIFT_W'(ok ? 12 : 0), "R5 sector shift", sector_shift_o, ok ? 12 : 0);
    check(frames == exp_frames, "R4 frame count", frames, exp_frames);
    check(flen[0] == 4, "R3 id frame length", flen[0], 4);
    if (ok) begin
      check(flen[1] == 1, "R6 enable frame length", flen[1], 1);
      check(flen[2] == 2, "R7 write frame length", flen[2], 2);
    end
    check(got_n == (ok ? 7 : 4), "R3 byte total", got_n, ok ? 7 : 4);
    for (int i = 0; i < (ok ? 7 : 4); i++) begin
      if (i < 4)       check(got[i] == exp_b[i], "R3 id byte",     got[i], exp_b[i]);
      else if (i == 4) check(got[i] == exp_b[i], "R6 enable byte", got[i], exp_b[i]);
      else             check(got[i] == exp_b[i], "R7 write byte",  got[i], exp_b[i]);
    end
    check(bad_hi == 0 && bad_lo == 0, "R9 sclk phases", bad_hi + bad_lo, 0);
    check(bad_mosi == 0 && bad_idle == 0, "R2 mode 0 timing", bad_mosi + bad_idle, 0);
    check(bad_gap == 0, "R8 cs gap", bad_gap, 0);
    if (full) begin
      repeat (40) @(negedge clk_i);
      check(done_o === 1'b1 && spi_cs_no === 1'b1, "R10 hold after done", {done_o, spi_cs_no}, 3);
      check(frames == exp_frames && error_o === !ok, "R10 no new frame", frames, exp_frames);
      check(sector_count_o == COUNT_W'(exp_cnt), "R10 geometry stable", sector_count_o, exp_cnt);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    run(8'hBF, 8'h25, 8'h4A, 1'b1);
    run(8'hBF, 8'h25, 8'h41, 1'b1);
    run(8'hBF, 8'h25, 8'h40, 1'b1);
    run(8'hBE, 8'h25, 8'h4A, 1'b1);
    run(8'hBF, 8'h26, 8'h41, 1'b1);
    for (int k = 0; k < 256; k++) run(8'hBF, 8'h25, 8'(k), 1'b0);  // R5 size sweep
    for (int k = 0; k < 256; k++) run(8'(k), 8'h25, 8'h41, 1'b0);  // R4 vendor sweep
    for (int k = 0; k < 256; k++) run(8'hBF, 8'(k), 8'h4A, 1'b0);  // R4 family sweep
    if (!wd_hit) begin
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule